// File: doc/BRIEF.md
# SPI Flash Command Frame Engine

This block runs one complete serial-flash transaction per request, all inside a single chip-select window. A transaction always begins with an 8-bit opcode. An address phase of one to four bytes may follow. A data phase may come last, and it either writes or reads a given number of bytes. A host fills in the opcode, the address, whether there is an address and how many bytes it has, the data direction and the byte count, then hands the request over with a valid/ready handshake. Write bytes come in on a byte-wide valid/ready stream. Read bytes go out on a second one.

The serial side uses SPI mode 0. The serial clock idles low and runs at half the system clock. Bits go out most significant bit first. MOSI changes only while the serial clock is low, and MISO is sampled at each rising serial-clock edge. When the write stream has no byte ready, or the read stream is not accepting, the serial clock stops low with chip-select still asserted. It resumes once the stream can move. When a request asks for an address phase of zero bytes, or of more bytes than the address holds, the block raises an error pulse and runs nothing on the bus.

Top module: `spi_cmd_frame`

## Requirements
- R1: The opcode is the first byte of every frame. Every byte is shifted most significant bit first. SCLK is low whenever CS_n is high, and MOSI never changes in a cycle where SCLK rises.
- R2: With an address phase of N bytes, the frame carries only the low N bytes of the 32-bit address, sent after the opcode and highest byte first: byte k is bits [8*(N-1-k)+7 : 8*(N-1-k)].
- R3: A request with an address phase and an address byte count of 0, or of more than 4, gives a one-cycle err_o pulse in the cycle after acceptance. CS_n stays high, SCLK does not toggle and busy_o stays low.
- R4: A write-direction request with an address and a byte count of 0 releases CS_n right after the last address byte: the window holds exactly 8*(1+N) SCLK rising edges.
- R5: A request with no address and a byte count of 0 sends only the opcode: the window holds exactly 8 SCLK rising edges.
- R6: A read-direction request (req_read_i = 1) clocks in count bytes after the opcode and address, drives 0 on MOSI for each of them, and delivers them in order on the read stream. Each byte is assembled from MISO bits sampled on SCLK rising edges, most significant bit first.
- R7: A write-direction request (req_read_i = 0) sends count bytes taken in order from the write stream. While no write byte is offered, SCLK holds low with CS_n asserted.
- R8: Once CS_n rises it stays high for at least two system clock cycles before the next frame asserts it.
- R9: busy_o is high from the cycle after request acceptance until CS_n is released, and it is high whenever CS_n is low. done_o pulses for exactly one cycle when CS_n rises.
- R10: While rd_valid_o is high and rd_ready_i is low, rd_data_o and rd_valid_o hold and SCLK stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Engine idle and able to take a request |
| req_opcode_i | input | 8 | Command opcode |
| req_addr_i | input | ADDR_W | Byte address; only the low N bytes are sent |
| req_has_addr_i | input | 1 | 1 = frame has an address phase |
| req_addr_bytes_i | input | 3 | Address byte count N (valid 1..4) |
| req_read_i | input | 1 | 1 = data phase reads, 0 = data phase writes |
| req_count_i | input | CNT_W | Data phase byte count (0 = no data phase) |
| wr_valid_i | input | 1 | Write byte offered |
| wr_ready_o | output | 1 | Write byte taken this cycle |
| wr_data_i | input | 8 | Write byte |
| rd_valid_o | output | 1 | Read byte available |
| rd_ready_i | input | 1 | Consumer takes the read byte |
| rd_data_o | output | 8 | Read byte |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse when chip-select is released |
| err_o | output | 1 | One-cycle pulse for a rejected request |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to the flash |
| cs_n_o | output | 1 | Active-low chip-select |
| miso_i | input | 1 | Serial data from the flash |

## Verification
A wrong phase counter or address index shows up directly in the captured MOSI stream. The bytes come out in the wrong order, or the frame has the wrong number of SCLK edges, and this is visible as soon as CS_n rises on that same frame. A bit counter that is off by one shifts every following bit, so the opcode byte itself is already wrong and a bad frame is caught within its first byte. A sequencer that mishandles a stall or a hold can leave the serial clock running or the handshake outputs wandering. The stall checks compare SCLK edge counts and held read data across a window of idle cycles, so this kind of fault surfaces within about ten cycles.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP,
    ST_OPC,
    ST_ADDR,
    ST_WDATA,
    ST_WWAIT,
    ST_RDATA,
    ST_RHOLD,
    ST_END,
    ST_GAP
  } seq_state_e;

  // Byte idx (0 = first on the wire) of the low n bytes of a, highest first.
  function automatic logic [7:0] addr_byte_pick(input logic [63:0] a,
                                                input int n, input int idx);
    int sh;
    sh = (n - 1 - idx) * 8;
    if (sh < 0 || sh > 56) return 8'h00;
    return 8'(a >> sh);
  endfunction

  // An address phase needs between 1 and max_bytes bytes.
  function automatic logic addr_width_ok(input logic has, input int n,
                                         input int max_bytes);
    return !has || (n >= 1 && n <= max_bytes);
  endfunction

endpackage

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  output logic       done_o,
  output logic [7:0] rx_o,
  output logic       sclk_o,
  output logic       mosi_o,
  input  logic       miso_i
);

  logic       active_q;
  logic       phase_q;   // 0: SCLK low half, 1: SCLK high half
  logic [2:0] bit_q;
  logic [7:0] tx_sh_q;
  logic [7:0] rx_sh_q;
  logic       sclk_q;
  logic       mosi_q;

  // Last falling edge of the byte is taken at this clock edge.
  assign done_o = active_q && phase_q && (bit_q == 3'd7);
  assign rx_o   = rx_sh_q;
  assign sclk_o = sclk_q;
  assign mosi_o = mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      bit_q    <= 3'd0;
      tx_sh_q  <= 8'h00;
      rx_sh_q  <= 8'h00;
      sclk_q   <= 1'b0;
      mosi_q   <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      phase_q  <= 1'b0;
      bit_q    <= 3'd0;
      tx_sh_q  <= tx_i;
      mosi_q   <= tx_i[7];
      sclk_q   <= 1'b0;
    end else if (active_q) begin
      if (!phase_q) begin
        sclk_q  <= 1'b1;
        rx_sh_q <= {rx_sh_q[6:0], miso_i};
        phase_q <= 1'b1;
      end else begin
        sclk_q  <= 1'b0;
        phase_q <= 1'b0;
        if (bit_q == 3'd7) begin
          active_q <= 1'b0;
          mosi_q   <= 1'b0;
        end else begin
          bit_q   <= bit_q + 3'd1;
          tx_sh_q <= {tx_sh_q[6:0], 1'b0};
          mosi_q  <= tx_sh_q[6];
        end
      end
    end
  end

  AST_MOSI_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> $stable(mosi_q)); // R1

  AST_START_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (!active_q || done_o)); // R1

endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq
  import spi_frame_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 12,
  parameter int GAP_CYC = 2,
  localparam int ADDR_BYTES = ADDR_W / 8,
  localparam int AB_W       = $clog2(ADDR_BYTES + 1),
  localparam int GAP_W      = $clog2(GAP_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [7:0]        req_opcode_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_has_addr_i,
  input  logic [AB_W-1:0]   req_addr_bytes_i,
  input  logic              req_read_i,
  input  logic [CNT_W-1:0]  req_count_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [7:0]        wr_data_i,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic [7:0]        rd_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              cs_n_o,
  output logic              sh_start_o,
  output logic [7:0]        sh_tx_o,
  input  logic              sh_done_i,
  input  logic [7:0]        sh_rx_i
);

  seq_state_e        state_q;
  logic [7:0]        opc_q;
  logic [ADDR_W-1:0] addr_q;
  logic              has_q;
  logic [AB_W-1:0]   nb_q;
  logic              rd_q;
  logic [CNT_W-1:0]  rem_q;
  logic [AB_W-1:0]   aidx_q;
  logic              cs_n_q;
  logic              busy_q;
  logic              done_q;
  logic              err_q;
  logic              rd_valid_q;
  logic [7:0]        rd_data_q;
  logic [GAP_W-1:0]  gap_q;

  // Named internal events
  logic addr_left_w;
  logic advance_w;
  logic nxt_addr_w;
  logic nxt_data_w;
  logic nxt_end_w;
  logic req_ok_w;
  logic accept_w;

  assign addr_left_w = has_q && (aidx_q != nb_q);
  assign advance_w   = ((state_q == ST_OPC || state_q == ST_ADDR ||
                         state_q == ST_WDATA) && sh_done_i) ||
                       (state_q == ST_WWAIT && wr_valid_i) ||
                       (state_q == ST_RHOLD && rd_ready_i);
  assign nxt_addr_w  = advance_w && addr_left_w;
  assign nxt_data_w  = advance_w && !addr_left_w && (rem_q != '0);
  assign nxt_end_w   = advance_w && !addr_left_w && (rem_q == '0);
  assign req_ok_w    = addr_width_ok(req_has_addr_i, int'(req_addr_bytes_i),
                                     ADDR_BYTES);
  assign accept_w    = (state_q == ST_IDLE) && req_valid_i;

  assign req_ready_o = (state_q == ST_IDLE);
  assign wr_ready_o  = nxt_data_w && !rd_q && wr_valid_i;
  assign sh_start_o  = (state_q == ST_SETUP) || nxt_addr_w ||
                       (nxt_data_w && (rd_q || wr_valid_i));

  always_comb begin
    sh_tx_o = 8'h00;
    if (state_q == ST_SETUP) begin
      sh_tx_o = opc_q;
    end else if (nxt_addr_w) begin
      sh_tx_o = addr_byte_pick(64'(addr_q), int'(nb_q), int'(aidx_q));
    end else if (nxt_data_w && !rd_q) begin
      sh_tx_o = wr_data_i;
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign cs_n_o     = cs_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      opc_q      <= 8'h00;
      addr_q     <= '0;
      has_q      <= 1'b0;
      nb_q       <= '0;
      rd_q       <= 1'b0;
      rem_q      <= '0;
      aidx_q     <= '0;
      cs_n_q     <= 1'b1;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= 8'h00;
      gap_q      <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;

      unique case (state_q)
        ST_IDLE: begin
          if (accept_w) begin
            if (!req_ok_w) begin
              err_q <= 1'b1;
            end else begin
              opc_q   <= req_opcode_i;
              addr_q  <= req_addr_i;
              has_q   <= req_has_addr_i;
              nb_q    <= req_addr_bytes_i;
              rd_q    <= req_read_i;
              rem_q   <= req_count_i;
              aidx_q  <= '0;
              cs_n_q  <= 1'b0;
              busy_q  <= 1'b1;
              state_q <= ST_SETUP;
            end
          end
        end
        ST_SETUP: state_q <= ST_OPC;
        ST_RDATA: begin
          if (sh_done_i) begin
            rd_data_q  <= sh_rx_i;
            rd_valid_q <= 1'b1;
            state_q    <= ST_RHOLD;
          end
        end
        ST_RHOLD: begin
          if (rd_ready_i) rd_valid_q <= 1'b0;
        end
        ST_END: begin
          cs_n_q  <= 1'b1;
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          gap_q   <= '0;
          state_q <= ST_GAP;
        end
        ST_GAP: begin
          gap_q <= gap_q + GAP_W'(1);
          if (gap_q == GAP_W'(GAP_CYC - 1)) state_q <= ST_IDLE;
        end
        default: ;
      endcase

      if (nxt_addr_w) begin
        aidx_q  <= aidx_q + AB_W'(1);
        state_q <= ST_ADDR;
      end else if (nxt_data_w) begin
        if (rd_q) begin
          rem_q   <= rem_q - CNT_W'(1);
          state_q <= ST_RDATA;
        end else if (wr_valid_i) begin
          rem_q   <= rem_q - CNT_W'(1);
          state_q <= ST_WDATA;
        end else begin
          state_q <= ST_WWAIT;
        end
      end else if (nxt_end_w) begin
        state_q <= ST_END;
      end
    end
  end

  AST_ERR_KEEPS_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (cs_n_q && !busy_q)); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R9

  AST_BUSY_COVERS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_q |-> busy_q); // R9

  AST_CS_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_q) |=> cs_n_q ##1 cs_n_q); // R8

  AST_RD_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_q && !rd_ready_i) |=> (rd_valid_q && $stable(rd_data_q))); // R10

  AST_WR_WAIT_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WWAIT && !wr_valid_i) |-> !sh_start_o); // R7

endmodule

// File: rtl/spi_cmd_frame.sv
module spi_cmd_frame #(
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 12,
  parameter int GAP_CYC = 2,
  localparam int ADDR_BYTES = ADDR_W / 8,
  localparam int AB_W       = $clog2(ADDR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [7:0]        req_opcode_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_has_addr_i,
  input  logic [AB_W-1:0]   req_addr_bytes_i,
  input  logic              req_read_i,
  input  logic [CNT_W-1:0]  req_count_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [7:0]        wr_data_i,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic [7:0]        rd_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              cs_n_o,
  input  logic              miso_i
);

  logic       sh_start_w;
  logic [7:0] sh_tx_w;
  logic       sh_done_w;
  logic [7:0] sh_rx_w;

  spi_frame_seq #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .GAP_CYC(GAP_CYC)
  ) seq_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid_i     (req_valid_i),
    .req_ready_o     (req_ready_o),
    .req_opcode_i    (req_opcode_i),
    .req_addr_i      (req_addr_i),
    .req_has_addr_i  (req_has_addr_i),
    .req_addr_bytes_i(req_addr_bytes_i),
    .req_read_i      (req_read_i),
    .req_count_i     (req_count_i),
    .wr_valid_i      (wr_valid_i),
    .wr_ready_o      (wr_ready_o),
    .wr_data_i       (wr_data_i),
    .rd_valid_o      (rd_valid_o),
    .rd_ready_i      (rd_ready_i),
    .rd_data_o       (rd_data_o),
    .busy_o          (busy_o),
    .done_o          (done_o),
    .err_o           (err_o),
    .cs_n_o          (cs_n_o),
    .sh_start_o      (sh_start_w),
    .sh_tx_o         (sh_tx_w),
    .sh_done_i       (sh_done_w),
    .sh_rx_i         (sh_rx_w)
  );

  spi_frame_shifter shifter_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(sh_start_w),
    .tx_i   (sh_tx_w),
    .done_o (sh_done_w),
    .rx_o   (sh_rx_w),
    .sclk_o (sclk_o),
    .mosi_o (mosi_o),
    .miso_i (miso_i)
  );

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o); // R1

  AST_HOLD_STOPS_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i) |-> !sclk_o); // R10

endmodule

// File: tb/spi_cmd_frame_tb_top.sv
`timescale 1ns/1ps
module spi_cmd_frame_tb_top;

  localparam int CNT_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [7:0]       req_opcode = 8'h00;
  logic [31:0]      req_addr = 32'h0;
  logic             req_has_addr = 1'b0;
  logic [2:0]       req_addr_bytes = 3'd0;
  logic             req_read = 1'b0;
  logic [CNT_W-1:0] req_count = '0;
  logic             wr_valid = 1'b0;
  logic             wr_ready;
  logic [7:0]       wr_data = 8'h00;
  logic             rd_valid;
  logic             rd_ready = 1'b0;
  logic [7:0]       rd_data;
  logic             busy, done, err, sclk, mosi, cs_n, miso;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  spi_cmd_frame #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_opcode_i(req_opcode), .req_addr_i(req_addr),
    .req_has_addr_i(req_has_addr), .req_addr_bytes_i(req_addr_bytes),
    .req_read_i(req_read), .req_count_i(req_count),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_data_i(wr_data),
    .rd_valid_o(rd_valid), .rd_ready_i(rd_ready), .rd_data_o(rd_data),
    .busy_o(busy), .done_o(done), .err_o(err),
    .sclk_o(sclk), .mosi_o(mosi), .cs_n_o(cs_n), .miso_i(miso)
  );

  task automatic chk(input bit ok, input string tag, input longint act,
                     input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Flash response byte for position k of a frame
  function automatic logic [7:0] resp_byte(input int k);
    return 8'((k * 53 + 60) ^ 165);
  endfunction

  function automatic logic resp_bit(input int p);
    logic [7:0] b;
    b = resp_byte(p / 8);
    return b[7 - (p % 8)];
  endfunction

  function automatic logic [7:0] exp_addr_byte(input logic [31:0] a,
                                               input int n, input int k);
    logic [31:0] s;
    s = a >> (8 * (n - 1 - k));
    return s[7:0];
  endfunction

  // ---------------- flash model ----------------
  logic [7:0] cap [0:63];
  logic [7:0] cur = 8'h00;
  int bitn = 0;
  int txptr = 0;
  int sclk_edges = 0;

  always @(negedge cs_n) begin
    bitn = 0;
    txptr = 0;
  end
  always @(posedge sclk) begin
    sclk_edges++;
    if (!cs_n) begin
      cur = {cur[6:0], mosi};
      bitn++;
      if (bitn % 8 == 0 && bitn / 8 <= 64) cap[bitn/8-1] = cur;
    end
  end
  always @(negedge sclk) if (!cs_n) txptr = bitn;
  assign miso = cs_n ? 1'b0 : resp_bit(txptr);

  // ---------------- monitors ----------------
  int  hi_cnt = 100;
  logic prev_cs = 1'b1;
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_n) hi_cnt++;
      else begin
        if (prev_cs) chk(hi_cnt >= 2, "R8 cs_n high gap", hi_cnt, 2);
        hi_cnt = 0;
      end
      if (done && prev_done) chk(0, "R9 done longer than one cycle", 2, 1);
      prev_cs = cs_n;
      prev_done = done;
    end
  end

  // ---------------- transaction ----------------
  logic [7:0] wbuf [0:63];
  logic [7:0] rbuf [0:63];

  task automatic run_tx(input logic [7:0] opc, input logic [31:0] a,
                        input bit has, input int n, input bit rd, input int cnt,
                        input bit hold);
    int na;
    int nb;
    int w;
    string tag;
    na = has ? n : 0;
    nb = 1 + na + cnt;
    for (int i = 0; i < cnt; i++) wbuf[i] = 8'($urandom);
    @(negedge clk);
    req_opcode = opc; req_addr = a; req_has_addr = has;
    req_addr_bytes = 3'(n); req_read = rd; req_count = CNT_W'(cnt);
    req_valid = 1'b1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && !cs_n, "R9 busy and cs_n after accept", {busy, cs_n}, 2'b10);
    w = 0;
    fork
      begin : feed
        int i;
        i = 0;
        while (i < cnt && !rd) begin
          if ($urandom % 3 == 0) begin
            wr_valid = 1'b0;
          end else begin
            wr_valid = 1'b1;
            wr_data = wbuf[i];
            #1;
            if (wr_ready) i++;
          end
          @(negedge clk);
        end
        wr_valid = 1'b0;
      end
      begin : consume
        int j;
        bit held;
        j = 0;
        held = 0;
        while (j < cnt && rd) begin
          if (hold && !held && rd_valid) begin
            int e0;
            logic [7:0] d0;
            held = 1;
            rd_ready = 1'b0;
            e0 = sclk_edges;
            d0 = rd_data;
            repeat (10) @(negedge clk);
            chk(sclk_edges == e0, "R10 sclk stopped while read held",
                sclk_edges, e0);
            chk(rd_valid && rd_data == d0, "R10 read byte held",
                {rd_valid, rd_data}, {1'b1, d0});
          end
          rd_ready = ($urandom % 3 != 0);
          #1;
          if (rd_valid && rd_ready) begin
            rbuf[j] = rd_data;
            j++;
          end
          @(negedge clk);
        end
        rd_ready = 1'b0;
      end
      begin : waitdone
        while (!done && w < 5000) begin @(negedge clk); w++; end
      end
    join
    chk(w < 5000, "R9 done pulse arrives", w, 5000);
    chk(!busy && cs_n, "R9 busy low and cs_n high at done", {busy, cs_n}, 2'b01);
    if (has && cnt == 0 && !rd) tag = "R4 bits in window";
    else if (!has && cnt == 0) tag = "R5 bits in window";
    else tag = "R2 bits in window";
    chk(bitn == 8 * nb, tag, bitn, 8 * nb);
    chk(cap[0] == opc, "R1 opcode byte", cap[0], opc);
    for (int k = 0; k < na; k++)
      chk(cap[1+k] == exp_addr_byte(a, n, k), "R2 address byte", cap[1+k],
          exp_addr_byte(a, n, k));
    for (int k = 0; k < cnt; k++) begin
      if (rd) begin
        chk(cap[1+na+k] == 8'h00, "R6 MOSI zero in read", cap[1+na+k], 0);
        chk(rbuf[k] == resp_byte(1 + na + k), "R6 read byte", rbuf[k],
            resp_byte(1 + na + k));
      end else begin
        chk(cap[1+na+k] == wbuf[k], "R7 write byte", cap[1+na+k], wbuf[k]);
      end
    end
  endtask

  task automatic run_bad(input int n);
    int e0;
    e0 = sclk_edges;
    @(negedge clk);
    req_opcode = 8'h5A; req_addr = 32'h1234_5678; req_has_addr = 1'b1;
    req_addr_bytes = 3'(n); req_read = 1'b0; req_count = CNT_W'(2);
    req_valid = 1'b1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
    chk(err, "R3 err pulse", err, 1);
    chk(cs_n && !busy, "R3 no frame started", {cs_n, busy}, 2'b10);
    repeat (5) @(negedge clk);
    chk(!err && sclk_edges == e0 && cs_n, "R3 bus stays quiet",
        sclk_edges, e0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL R9 watchdog actual=timeout expected=completion");
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && !sclk && !busy && !done && !err && !rd_valid && req_ready,
        "R1 reset state", {cs_n, sclk, busy, done, err, rd_valid, req_ready},
        7'b1000001);

    run_tx(8'h06, 32'h0, 1'b0, 0, 1'b0, 0, 1'b0);           // R5
    run_tx(8'hD8, 32'hA1B2_C3D4, 1'b1, 4, 1'b0, 0, 1'b0);   // R4
    run_tx(8'h20, 32'h00FE_DC10, 1'b1, 1, 1'b0, 0, 1'b0);   // R4
    run_tx(8'h05, 32'h0, 1'b0, 0, 1'b1, 1, 1'b0);           // R6
    run_tx(8'h03, 32'h0012_3456, 1'b1, 3, 1'b1, 4, 1'b1);   // R10
    run_tx(8'h02, 32'hCAFE_0100, 1'b1, 2, 1'b0, 5, 1'b0);   // R7
    run_tx(8'h9F, 32'h0, 1'b0, 0, 1'b1, 3, 1'b0);           // R6
    run_bad(0);
    run_bad(5);
    run_bad(7);

    for (int t = 0; t < 40; t++) begin
      bit has;
      has = ($urandom % 2) != 0;
      run_tx(8'($urandom), $urandom, has, 1 + int'($urandom % 4),
             ($urandom % 2) != 0, int'($urandom % 7), ($urandom % 4) == 0);
    end

    repeat (10) @(negedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule